// File: doc/BRIEF.md
# Serial Converter Output Sequencer

This block produces the digital conversion timing and the serial output stream of a sampling converter that is controlled by one active-low select line. A parallel sample word comes from an abstract digitizer. The block captures that word at the start of a conversion frame and sends it out one bit per clock, most significant bit first. It also produces an output-enable flag that stands for the tri-state condition of the serial pin.

A frame is a fixed number of clock cycles. It opens on the first rising edge at which the select line is seen low. There is no mode register: the block infers its behaviour from the select level when a frame closes.

- If select is high at the close, the line goes to high impedance and the block waits. This covers both the single-shot use and a later synchronized restart.
- If select is still low at the close, the next frame follows with no gap. In this free-running case the line is held driven low between the data windows.

Top module: `sser_seq`

## Requirements
- R1: A frame begins on the first rising clock edge at which `sel_n` is sampled low while idle. That edge is frame clock 1.
- R2: Every frame lasts exactly 12 clock cycles. With default parameters, frame clock k+1 follows frame clock k on the next rising edge, up to k = 12.
- R3: The 8 data bits are driven MSB first on `sdo`, with `sdo_oe` = 1. Bit 7 appears after the falling edge of frame clock 4, and bit (11-k) after the falling edge of frame clock k, for k = 4 to 11.
- R4: At the falling edge of frame clock 12, if `sel_n` is high, `sdo_oe` goes to 0. It stays 0, with `sdo` = 0, and no frame starts while `sel_n` stays high.
- R5: If `sel_n` is low at the falling edge of frame clock 12, the next rising edge is frame clock 1 of a new frame. No idle cycle is inserted.
- R6: In free run, `sdo_oe` stays 1 and `sdo` = 0 from the falling edge of clock 12 through the falling edge of clock 3 of the next frame. In the first frame after idle, `sdo_oe` is 0 during clocks 1 to 3.
- R7: `sample` is captured on the rising edge of frame clock 1. Later changes to `sample` have no effect on the bits sent in that frame.
- R8: A rise of `sel_n` during frame clocks 1 to 11 has no effect. The frame completes and its bits are sent unchanged.
- R9: While `rst_n` is low at a clock edge, the block returns to idle. `sdo_oe` = 0, `sdo` = 0, and no frame is in progress after reset releases.
- R10: After a frame that closed with `sel_n` high, driving `sel_n` low at any later time starts a frame on the next rising edge. `sdo_oe` stays 0 while waiting and during clocks 1 to 3 of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; control on rising edges, serial output on falling edges |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low select that starts and continues conversions |
| sample | input | W (8) | Parallel sample word from the digitizer |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable; 0 means the serial pin is high impedance |

## Verification
Frames are driven from a table that mixes three select patterns:
- A single frame released at its end. This separates a close to high impedance from a close into free run.
- Chains of back-to-back frames. These show that there is no gap and that the low level is driven between data windows.
- Frames with select raised mid-frame. These show that only the end-of-frame level matters.

Each frame scrambles `sample` after the capture edge, so a late capture shows up as wrong bits. The data words (A5, 80, 3C, FF, 01, 5A) tell bit order and bit position apart. A reset applied partway through a frame, followed by a fresh start, confirms that no state from the aborted frame leaks into the next one.

// File: rtl/ssq_pkg.sv
// Shared definitions for the serial converter output sequencer.
// Assumes: the frame length is the lead-in cycles plus one cycle per data bit.
package ssq_pkg;

    // Default word width and number of lead-in clocks before the first bit.
    localparam int SSQ_W    = 8;
    localparam int SSQ_LEAD = 4;

    // Position of the current clock inside a frame, as seen by the output stage.
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,   // no frame in progress
        PH_LEAD = 2'd1,   // frame clocks 1 .. LEAD-1
        PH_DATA = 2'd2,   // frame clocks LEAD .. FRAME-1, one bit each
        PH_TAIL = 2'd3    // frame clock FRAME, end-of-frame decision
    } ssq_phase_e;

endpackage

// File: rtl/ssq_frame_ctrl.sv
// Frame controller: runs on rising edges.
// It starts a frame when select is low while idle, counts the frame clocks,
// captures the sample word on clock 1, and at the last clock either chains
// straight into a new frame or returns to idle.
// Assumes: cont_i was computed by the output stage at the falling edge of the
// last frame clock and stays stable until the next rising edge.
module ssq_frame_ctrl
    import ssq_pkg::*;
#(
    parameter int W    = SSQ_W,
    parameter int LEAD = SSQ_LEAD,
    localparam int FRAME = LEAD + W,
    localparam int CW    = $clog2(FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic [W-1:0]  sample,
    input  logic          cont_i,
    output logic          busy_o,
    output logic [CW-1:0] cnt_o,
    output logic [W-1:0]  word_o,
    output logic          fr_o
);

    localparam logic [CW-1:0] LAST = CW'(FRAME);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  word_q;
    logic          fr_q;

    // Frame sequencing: start, count, chain or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            fr_q   <= 1'b0;
        end else if (busy_q && cnt_q == LAST) begin
            if (cont_i) begin
                cnt_q <= ONE;
                fr_q  <= 1'b1;
            end else if (!sel_n) begin
                cnt_q <= ONE;
                fr_q  <= 1'b0;
            end else begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
                fr_q   <= 1'b0;
            end
        end else if (busy_q) begin
            cnt_q <= cnt_q + ONE;
        end else if (!sel_n) begin
            busy_q <= 1'b1;
            cnt_q  <= ONE;
            fr_q   <= 1'b0;
        end
    end

    // Sample capture: load the word on every frame clock 1, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if ((busy_q && cnt_q == LAST && (cont_i || !sel_n)) ||
                     (!busy_q && !sel_n)) begin
            word_q <= sample;
        end
    end

    assign busy_o = busy_q;
    assign cnt_o  = cnt_q;
    assign word_o = word_q;
    assign fr_o   = fr_q;

    // R2: the counter stays inside 1..FRAME during a frame.
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q >= ONE && cnt_q <= LAST));

    // R2: inside a frame the count advances by one every rising edge.
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q < LAST) |=> (busy_q && cnt_q == $past(cnt_q) + ONE));

    // R7: the captured word is held for the rest of the frame.
    a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q < LAST) |=> $stable(word_q));

    // R4: while idle with select high, no frame starts.
    a_r4_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && sel_n) |=> !busy_q);

    // R8: a frame in progress never stops before its last clock.
    a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q < LAST) |=> busy_q);

endmodule

// File: rtl/ssq_phase_dec.sv
// Phase decoder: classifies the current frame clock into lead-in, data or
// tail, and gives the index of the data bit for that clock.
// Assumes: cnt is in 1..LEAD+W whenever busy is high.
module ssq_phase_dec
    import ssq_pkg::*;
#(
    parameter int W    = SSQ_W,
    parameter int LEAD = SSQ_LEAD,
    localparam int FRAME = LEAD + W,
    localparam int CW    = $clog2(FRAME + 1),
    localparam int IW    = (W > 1) ? $clog2(W) : 1
) (
    input  logic          busy,
    input  logic [CW-1:0] cnt,
    output ssq_phase_e    phase,
    output logic [IW-1:0] bit_idx
);

    localparam logic [CW-1:0] LEAD_C = CW'(LEAD);
    localparam logic [CW-1:0] LAST   = CW'(FRAME);
    localparam logic [CW-1:0] TOPBIT = CW'(FRAME - 1);

    logic [CW-1:0] idx_full;

    // Phase selection from the frame clock number.
    always_comb begin
        if (!busy)              phase = PH_OFF;
        else if (cnt < LEAD_C)  phase = PH_LEAD;
        else if (cnt < LAST)    phase = PH_DATA;
        else                    phase = PH_TAIL;
    end

    // Bit index: first data clock maps to the MSB.
    always_comb begin
        idx_full = TOPBIT - cnt;
        bit_idx  = idx_full[IW-1:0];
    end

endmodule

// File: rtl/ssq_out_stage.sv
// Output stage: runs on falling edges.
// It drives the serial bit and the output enable from the frame phase, and at
// the last frame clock samples select to decide between free run and stop.
// Assumes: the phase and word inputs were updated on the preceding rising edge.
module ssq_out_stage
    import ssq_pkg::*;
#(
    parameter int W  = SSQ_W,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  ssq_phase_e    phase,
    input  logic [IW-1:0] bit_idx,
    input  logic [W-1:0]  word,
    input  logic          fr,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          cont_o
);

    logic sdo_q, oe_q, cont_q;

    // Falling-edge drive of the serial line and the end-of-frame decision.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sdo_q  <= 1'b0;
            oe_q   <= 1'b0;
            cont_q <= 1'b0;
        end else begin
            unique case (phase)
                PH_LEAD: begin
                    sdo_q  <= 1'b0;
                    oe_q   <= fr;
                    cont_q <= 1'b0;
                end
                PH_DATA: begin
                    sdo_q  <= word[bit_idx];
                    oe_q   <= 1'b1;
                    cont_q <= 1'b0;
                end
                PH_TAIL: begin
                    sdo_q  <= 1'b0;
                    oe_q   <= !sel_n;
                    cont_q <= !sel_n;
                end
                default: begin
                    sdo_q  <= 1'b0;
                    oe_q   <= 1'b0;
                    cont_q <= 1'b0;
                end
            endcase
        end
    end

    assign sdo    = sdo_q;
    assign sdo_oe = oe_q;
    assign cont_o = cont_q;

    // R3: every data clock leaves the line enabled.
    a_r3_data_enabled: assert property (@(negedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |=> sdo_oe);

    // R4: with no frame in progress the line is released.
    a_r4_off_released: assert property (@(negedge clk) disable iff (!rst_n)
        (phase == PH_OFF) |=> (!sdo_oe && !sdo));

    // R6: outside the data window the driven level is always low.
    a_r6_gap_low: assert property (@(negedge clk) disable iff (!rst_n)
        (phase == PH_LEAD || phase == PH_TAIL) |=> !sdo);

endmodule

// File: rtl/sser_seq.sv
// Serial converter output sequencer, top level.
// It connects the rising-edge frame controller, the phase decoder and the
// falling-edge output stage.
// Assumes: sel_n and sample are synchronous to clk.
module sser_seq
    import ssq_pkg::*;
#(
    parameter int W    = SSQ_W,
    parameter int LEAD = SSQ_LEAD,
    localparam int FRAME = LEAD + W,
    localparam int CW    = $clog2(FRAME + 1),
    localparam int IW    = (W > 1) ? $clog2(W) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic [W-1:0] sample,
    output logic         sdo,
    output logic         sdo_oe
);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [W-1:0]  word;
    logic          fr;
    logic          cont;
    ssq_phase_e    phase;
    logic [IW-1:0] bit_idx;

    ssq_frame_ctrl #(.W(W), .LEAD(LEAD)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .sample (sample),
        .cont_i (cont),
        .busy_o (busy),
        .cnt_o  (cnt),
        .word_o (word),
        .fr_o   (fr)
    );

    ssq_phase_dec #(.W(W), .LEAD(LEAD)) u_dec (
        .busy    (busy),
        .cnt     (cnt),
        .phase   (phase),
        .bit_idx (bit_idx)
    );

    ssq_out_stage #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .phase   (phase),
        .bit_idx (bit_idx),
        .word    (word),
        .fr      (fr),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe),
        .cont_o  (cont)
    );

endmodule

// File: tb/test_sser_seq.sv
`timescale 1ns/1ps
module test_sser_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic [7:0] sample = 8'h00;
    logic       sdo, sdo_oe;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    sser_seq i_sser_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .sample (sample),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    // Frame table: {word, select high during clocks 1..11, select low at clock 12}
    localparam logic [9:0] TBL [6] = '{
        {8'hA5, 1'b0, 1'b0},
        {8'h80, 1'b1, 1'b0},
        {8'h3C, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b1},
        {8'h01, 1'b0, 1'b1},
        {8'h5A, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic exp_oe, input logic exp_sdo);
        n_run++;
        if (sdo_oe !== exp_oe || sdo !== exp_sdo) begin
            n_fail++;
            $display("FAIL %s: oe/sdo got %b/%b expected %b/%b at %0t",
                     req, sdo_oe, sdo, exp_oe, exp_sdo, $time);
        end
    endtask

    // One cycle: drive after the rising edge, sample after the falling edge.
    task automatic cycle(input logic s, input logic [7:0] smp);
        @(posedge clk); #1;
        sel_n  = s;
        sample = smp;
        @(negedge clk); #1;
    endtask

    // Frame clocks 1..12, assuming select was low at the previous rising edge.
    task automatic run_frame(input logic [7:0] w, input logic fr_in,
                             input logic mid_high, input logic keep_low,
                             input logic [7:0] next_w);
        for (int k = 1; k <= 12; k++) begin
            if (k == 12) cycle(!keep_low, keep_low ? next_w : ~w);
            else         cycle(mid_high, ~w);
            if (k < 4)       check(fr_in ? "R6 free-run lead low" : "R10/R6 lead released", fr_in, 1'b0);
            else if (k < 12) check(mid_high ? "R3/R7/R8 data bit" : "R3/R7 data bit", 1'b1, w[11-k]);
            else             check(keep_low ? "R5/R6 tail driven low" : "R4 tail released", keep_low, 1'b0);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic prev_keep;
        cycle(1'b1, 8'h00);
        cycle(1'b1, 8'h00);
        check("R9 reset state", 1'b0, 1'b0);
        @(posedge clk); #1; rst_n = 1'b1;

        prev_keep = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (!prev_keep) begin
                for (int g = 0; g <= i % 3; g++) begin
                    cycle(1'b1, 8'hEE);
                    check("R4 idle released", 1'b0, 1'b0);
                end
                cycle(1'b0, TBL[i][9:2]);
                check("R10 wait released", 1'b0, 1'b0);
            end
            run_frame(TBL[i][9:2], prev_keep, TBL[i][1], TBL[i][0],
                      (i < 5) ? TBL[i+1][9:2] : 8'h00);
            prev_keep = TBL[i][0];
        end
        for (int g = 0; g < 3; g++) begin
            cycle(1'b1, 8'h00);
            check("R4 stays idle", 1'b0, 1'b0);
        end

        // Reset in the middle of a data window.
        cycle(1'b0, 8'hC3);
        for (int k = 1; k <= 5; k++) cycle(1'b0, 8'hC3);
        check("R3 bit before reset", 1'b1, 1'b1);
        @(posedge clk); #1; rst_n = 1'b0; sel_n = 1'b1;
        @(negedge clk); #1;
        check("R9 reset mid-frame", 1'b0, 1'b0);
        cycle(1'b1, 8'h00);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk); #1;
        check("R9 idle after reset", 1'b0, 1'b0);
        for (int g = 0; g < 3; g++) begin
            cycle(1'b1, 8'h00);
            check("R9 no frame after reset", 1'b0, 1'b0);
        end

        // Fresh start after reset: first frame, then a chained second frame.
        cycle(1'b0, 8'h96);
        check("R1 wait released", 1'b0, 1'b0);
        run_frame(8'h96, 1'b0, 1'b0, 1'b1, 8'h69);
        run_frame(8'h69, 1'b1, 1'b0, 1'b0, 8'h00);
        cycle(1'b1, 8'h00);
        check("R2 idle after 12 clocks", 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule